// File: doc/BRIEF.md
# Delayed-write cache data array with forwarding

This block is the data storage of a data cache. A load names a line and a doubleword within it and gets the doubleword one cycle later. A store that has already been judged a hit presents its bytes with per-byte enables. A line refill presents one whole doubleword per cycle. Tag matching, hit decisions and the memory bus are handled elsewhere.

The RAM write is taken off the critical path. An accepted store or refill is first captured in a pending-write register and is written into the RAM one cycle later. A second register keeps the write that has just been committed for one more cycle. When the load data leaves the block, these two registers are compared with the load's index. Byte lanes they carry replace the bytes read from the RAM. A load therefore sees every store or refill accepted in the same cycle or in any earlier cycle, with no stall. This holds even for a load issued in the same cycle as the store, or in the cycle right after it.

Top module: `dsr_data_ram`

## Requirements
- R1: After reset is released, `rd_valid` is low and no write is pending.
- R2: `rd_valid` is high in exactly the cycles that follow a cycle with `rd_en` high. `rd_data` then holds the doubleword addressed in that earlier cycle.
- R3: A refill writes all bytes of the addressed doubleword. A load in the same cycle as the refill, or in any later cycle, returns the refilled value.
- R4: A store changes only the byte lanes whose `st_be` bit is set (bit b covers data bits 8b+7..8b). The other lanes keep their previous contents.
- R5: A load to the doubleword that a store is writing in the same cycle returns the stored bytes.
- R6: A load issued one cycle after a store to the same doubleword returns the stored bytes.
- R7: A load issued two or more cycles after a store to the same doubleword returns the stored bytes.
- R8: When the two most recent writes both hit a load's doubleword, the lanes of the younger write win. Lanes written only by the older write come from the older write.
- R9: Forwarding compares the full index, meaning the line number together with the doubleword select. A write to another line, or to another doubleword of the same line, never alters load data.
- R10: `st_en` and `rf_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Load request |
| rd_line | input | $clog2(LINES) | Load line number |
| rd_dw | input | SELW | Load doubleword within the line |
| rd_data | output | 8*BYTES | Load data, valid the cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a load result |
| st_en | input | 1 | Store hit accepted |
| st_line | input | $clog2(LINES) | Store line number |
| st_dw | input | SELW | Store doubleword within the line |
| st_be | input | BYTES | Store byte enables |
| st_data | input | 8*BYTES | Store data |
| rf_en | input | 1 | Refill doubleword accepted |
| rf_line | input | $clog2(LINES) | Refill line number |
| rf_dw | input | SELW | Refill doubleword within the line |
| rf_data | input | 8*BYTES | Refill data |

## Verification
The bench sweeps the distance between a store and a load from zero to three cycles. It does this for every byte-enable pattern and every index, and for loads to the same doubleword, to a neighbouring line and to the sibling doubleword. A design that writes the RAM too late or drops a stage would return stale bytes at distance one or zero. A design that compares only the line, or only the select, would corrupt data at neighbouring indices. A second sweep pairs every two back-to-back enable patterns on one doubleword. Reversed stage priority would return the older bytes in overlapping lanes, and forwarding whole words instead of lanes would wipe out lanes that were never written.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   // number of forwarding stages fixed by the one-cycle write delay
   localparam int FWD_DEPTH = 2;

   // width of the doubleword select field; at least one bit for the port
   function automatic int sel_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dsr_lane_ram.sv
module dsr_lane_ram #(
   parameter int DEPTH = 128,
   parameter int AW    = 7,
   parameter int NB    = 8
) (
   input  logic            clk,
   input  logic [NB-1:0]   we,
   input  logic [AW-1:0]   waddr,
   input  logic [NB*8-1:0] wdata,
   input  logic            re,
   input  logic [AW-1:0]   raddr,
   output logic [NB*8-1:0] rdata
);

   // one byte-wide RAM per lane so each lane has a single writer
   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [7:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we[b]) cells[waddr] <= wdata[b*8 +: 8];
      end

      always_ff @(posedge clk) begin
         if (re) rdata[b*8 +: 8] <= cells[raddr];
      end
   end

endmodule

// File: rtl/dsr_stage.sv
module dsr_stage #(
   parameter int AW = 7,
   parameter int NB = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_v,
   input  logic [AW-1:0]   in_addr,
   input  logic [NB-1:0]   in_be,
   input  logic [NB*8-1:0] in_data,
   output logic            out_v,
   output logic [AW-1:0]   out_addr,
   output logic [NB-1:0]   out_be,
   output logic [NB*8-1:0] out_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v    <= 1'b0;
         out_addr <= '0;
         out_be   <= '0;
         out_data <= '0;
      end else begin
         out_v    <= in_v;
         out_addr <= in_addr;
         out_be   <= in_be;
         out_data <= in_data;
      end
   end

endmodule

// File: rtl/dsr_fwd_merge.sv
module dsr_fwd_merge #(
   parameter int AW   = 7,
   parameter int NB   = 8,
   parameter int NSTG = 2
) (
   input  logic [AW-1:0]              raddr,
   input  logic [NB*8-1:0]            raw,
   input  logic [NSTG-1:0]            stg_v,
   input  logic [NSTG-1:0][AW-1:0]    stg_addr,
   input  logic [NSTG-1:0][NB-1:0]    stg_be,
   input  logic [NSTG-1:0][NB*8-1:0]  stg_data,
   output logic [NB*8-1:0]            merged
);

   // stage 0 is the youngest; walk oldest first so younger lanes overwrite
   always_comb begin
      merged = raw;
      for (int k = NSTG - 1; k >= 0; k--) begin
         for (int b = 0; b < NB; b++) begin
            if (stg_v[k] && (stg_addr[k] == raddr) && stg_be[k][b])
               merged[b*8 +: 8] = stg_data[k][b*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/dsr_data_ram.sv
module dsr_data_ram #(
   parameter int LINES       = 16,
   parameter int DW_PER_LINE = 8,
   parameter int BYTES       = 8,
   localparam int LINEW = $clog2(LINES),
   localparam int SELW  = dsr_pkg::sel_bits(DW_PER_LINE),
   localparam int DATAW = BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [LINEW-1:0] rd_line,
   input  logic [SELW-1:0]  rd_dw,
   output logic [DATAW-1:0] rd_data,
   output logic             rd_valid,
   input  logic             st_en,
   input  logic [LINEW-1:0] st_line,
   input  logic [SELW-1:0]  st_dw,
   input  logic [BYTES-1:0] st_be,
   input  logic [DATAW-1:0] st_data,
   input  logic             rf_en,
   input  logic [LINEW-1:0] rf_line,
   input  logic [SELW-1:0]  rf_dw,
   input  logic [DATAW-1:0] rf_data
);

   localparam int NSTG  = dsr_pkg::FWD_DEPTH;
   localparam int DEPTH = LINES * DW_PER_LINE;
   localparam int IDXW  = LINEW + ((DW_PER_LINE > 1) ? SELW : 0);

   // elaboration checks on the configuration
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (DW_PER_LINE < 1 || (DW_PER_LINE & (DW_PER_LINE - 1)) != 0) begin : g_bad_sel
      $error("DW_PER_LINE must be a power of two");
   end
   if (BYTES < 1) begin : g_bad_bytes
      $error("BYTES must be at least 1");
   end

   logic [IDXW-1:0] rd_idx, st_idx, rf_idx;

   if (DW_PER_LINE > 1) begin : g_sel
      assign rd_idx = {rd_line, rd_dw};
      assign st_idx = {st_line, st_dw};
      assign rf_idx = {rf_line, rf_dw};
   end else begin : g_nosel
      assign rd_idx = rd_line;
      assign st_idx = st_line;
      assign rf_idx = rf_line;
   end

   // accepted write, refill covers every lane
   logic             new_v;
   logic [IDXW-1:0]  new_addr;
   logic [BYTES-1:0] new_be;
   logic [DATAW-1:0] new_data;

   always_comb begin
      new_v    = st_en | rf_en;
      new_addr = rf_en ? rf_idx : st_idx;
      new_be   = rf_en ? {BYTES{1'b1}} : st_be;
      new_data = rf_en ? rf_data : st_data;
   end

   logic [NSTG-1:0]             stg_v;
   logic [NSTG-1:0][IDXW-1:0]   stg_addr;
   logic [NSTG-1:0][BYTES-1:0]  stg_be;
   logic [NSTG-1:0][DATAW-1:0]  stg_data;

   for (genvar k = 0; k < NSTG; k++) begin : g_stage
      logic             in_v;
      logic [IDXW-1:0]  in_addr;
      logic [BYTES-1:0] in_be;
      logic [DATAW-1:0] in_data;

      if (k == 0) begin : g_head
         assign in_v    = new_v;
         assign in_addr = new_addr;
         assign in_be   = new_be;
         assign in_data = new_data;
      end else begin : g_tail
         assign in_v    = stg_v[k-1];
         assign in_addr = stg_addr[k-1];
         assign in_be   = stg_be[k-1];
         assign in_data = stg_data[k-1];
      end

      dsr_stage #(.AW(IDXW), .NB(BYTES)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_v     (in_v),
         .in_addr  (in_addr),
         .in_be    (in_be),
         .in_data  (in_data),
         .out_v    (stg_v[k]),
         .out_addr (stg_addr[k]),
         .out_be   (stg_be[k]),
         .out_data (stg_data[k])
      );
   end

   // the head stage is the delayed RAM write
   logic [BYTES-1:0] ram_we;
   logic [DATAW-1:0] ram_q;

   assign ram_we = stg_v[0] ? stg_be[0] : '0;

   dsr_lane_ram #(.DEPTH(DEPTH), .AW(IDXW), .NB(BYTES)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (stg_addr[0]),
      .wdata (stg_data[0]),
      .re    (rd_en),
      .raddr (rd_idx),
      .rdata (ram_q)
   );

   logic [IDXW-1:0] rd_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_idx_q <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_idx_q <= rd_idx;
      end
   end

   dsr_fwd_merge #(.AW(IDXW), .NB(BYTES), .NSTG(NSTG)) u_merge (
      .raddr    (rd_idx_q),
      .raw      (ram_q),
      .stg_v    (stg_v),
      .stg_addr (stg_addr),
      .stg_be   (stg_be),
      .stg_data (stg_data),
      .merged   (rd_data)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!rd_valid && stg_v == '0));

   // R2
   rdv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R2
   rdv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R5
   write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_en || rf_en) |=> stg_v[0]);

   // R3
   refill_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_en |=> (&stg_be[0]));

   // R8
   stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg_v[0] |=> (stg_v[1] && stg_addr[1] == $past(stg_addr[0])));

   // R10
   one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_en && rf_en));

endmodule

// File: tb/dsr_data_ram_test.sv
`timescale 1ns/1ps
module dsr_data_ram_test;

   localparam int LINES = 4;
   localparam int DWPL  = 2;
   localparam int NB    = 4;
   localparam int DEPTH = LINES * DWPL;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_en, st_en, rf_en;
   logic [1:0]  rd_line, st_line, rf_line;
   logic [0:0]  rd_dw, st_dw, rf_dw;
   logic [31:0] rd_data, st_data, rf_data;
   logic [3:0]  st_be;
   logic        rd_valid;

   int checks = 0;
   int fails  = 0;
   int ncount = 0;
   logic [31:0] model [DEPTH];

   always #2.5 clk = ~clk;

   dsr_data_ram #(.LINES(LINES), .DW_PER_LINE(DWPL), .BYTES(NB)) uut (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_line(rd_line), .rd_dw(rd_dw),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .st_en(st_en), .st_line(st_line), .st_dw(st_dw),
      .st_be(st_be), .st_data(st_data),
      .rf_en(rf_en), .rf_line(rf_line), .rf_dw(rf_dw), .rf_data(rf_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int n);
      return 32'h9E37_79B9 * n + 32'(n);
   endfunction

   // one clock cycle: index = line*2 + dw; store lanes merged into model first
   task automatic tick(input bit s, input int sa, input logic [3:0] sbe,
                       input bit f, input int fa, input bit r, input int ra,
                       input string req);
      logic [31:0] sd, fd, exp;
      ncount++;
      sd = pat(ncount);
      fd = pat(ncount + 7001);
      st_en = s; st_line = 2'(sa >> 1); st_dw = 1'(sa); st_be = sbe; st_data = sd;
      rf_en = f; rf_line = 2'(fa >> 1); rf_dw = 1'(fa); rf_data = fd;
      rd_en = r; rd_line = 2'(ra >> 1); rd_dw = 1'(ra);
      if (s) for (int b = 0; b < NB; b++) if (sbe[b]) model[sa][b*8 +: 8] = sd[b*8 +: 8];
      if (f) model[fa] = fd;
      exp = model[ra];
      @(posedge clk);
      @(negedge clk);
      check("R2", {31'b0, rd_valid}, {31'b0, r});
      if (r) check(req, rd_data, exp);
   endtask

   initial begin
      rst_n = 1'b0;
      rd_en = 0; st_en = 0; rf_en = 0;
      rd_line = 0; rd_dw = 0; st_line = 0; st_dw = 0; rf_line = 0; rf_dw = 0;
      st_be = 0; st_data = 0; rf_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {31'b0, rd_valid}, 32'd0);

      // R3: refill every entry, load in the same cycle and again afterwards
      for (int a = 0; a < DEPTH; a++) tick(0, 0, 4'h0, 1, a, 1, a, "R3");
      for (int a = 0; a < DEPTH; a++) tick(0, 0, 4'h0, 0, 0, 1, a, "R3");
      for (int a = 0; a < DEPTH; a++) begin
         tick(0, 0, 4'h0, 1, a, 0, 0, "R3");
         tick(0, 0, 4'h0, 0, 0, 1, a, "R3");
      end

      // R4 R5 R6 R7 R9: store to load distance 0..3, same / other line / other dword
      for (int d = 0; d < 4; d++)
         for (int rel = 0; rel < 3; rel++)
            for (int sa = 0; sa < DEPTH; sa++)
               for (int be = 0; be < 16; be++) begin
                  int la;
                  string rq;
                  la = (rel == 0) ? sa : (rel == 1) ? (sa ^ 2) : (sa ^ 1);
                  if (rel != 0) rq = "R9";
                  else if (d == 0) rq = "R5";
                  else if (d == 1) rq = "R6";
                  else rq = (be == 5) ? "R4" : "R7";
                  tick(1, sa, 4'(be), 0, 0, (d == 0), la, rq);
                  for (int k = 1; k <= d; k++) tick(0, 0, 4'h0, 0, 0, (k == d), la, rq);
               end

      // R8: back-to-back stores with every pair of lane masks
      for (int b1 = 0; b1 < 16; b1++)
         for (int b2 = 0; b2 < 16; b2++) begin
            int a;
            a = (b1 + b2) % DEPTH;
            tick(1, a, 4'(b1), 0, 0, 0, 0, "R8");
            tick(1, a, 4'(b2), 0, 0, 1, a, "R8");
            tick(0, 0, 4'h0, 0, 0, 1, a, "R8");
         end

      // R8 with a refill as the older write
      for (int a = 0; a < DEPTH; a++) begin
         tick(0, 0, 4'h0, 1, a, 0, 0, "R8");
         tick(1, a, 4'h6, 0, 0, 1, a, "R8");
         tick(0, 0, 4'h0, 0, 0, 1, a, "R8");
      end

      tick(0, 0, 4'h0, 0, 0, 0, 0, "R2");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule